// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the address and count core of one DMA channel. Software loads a page, a start address and a transfer count. Each load goes into a base copy and a working copy in the same cycle. Each accepted transfer then moves the working address one step up or down and takes one from the working count. When the count runs out, the block raises a terminal-count pulse.

The 24-bit bus address is built from the working page and address. A per-instance parameter selects one of two layouts. In byte mode the count is in bytes and the page sits directly above the 16-bit address. In word mode the count is in 16-bit words. The address field is shifted up by one, bit 0 is zero, and the page's lowest bit is dropped.

At terminal count the channel does one of two things. It can mask itself and stop until software clears the mask. With autoinitialize enabled, it instead reloads every working register from the base copies and stays open for the next request.

Top module: `dma_addr_gen`

## Requirements
- R1: After synchronous reset, `bus_addr` is 0, `tc` is 0, `svc_req` is 0, `masked` is 1, and all base and working registers are 0.
- R2: A write with `wr_sel` = 0 loads the page, 1 loads the address and 2 loads the count; the value comes from `wr_data`, and a page write uses bits [7:0]. The base copy and the working copy of that register change on the same edge. The new address shows on `bus_addr` one cycle later.
- R3: In byte mode (`WORD_MODE` = 0), `bus_addr` = {page[7:0], address[15:0]}.
- R4: In word mode (`WORD_MODE` = 1), `bus_addr` = {page[7:1], address[15:0], 1'b0}. Page bit 0 has no effect on the output.
- R5: Each accepted transfer adds 1 to the working address when `mode_dec` = 0 and subtracts 1 when `mode_dec` = 1.
- R6: The working address wraps within 16 bits in both directions, and the page never changes because of a transfer.
- R7: Each accepted transfer takes 1 from the working count. `tc` pulses for one cycle after the transfer that finds the count at 0, so a programmed count N gives N+1 transfers.
- R8: A transfer is accepted only when `xfer_done` = 1, `dreq` = 1, `masked` = 0 and `wr_en` = 0. Any other `xfer_done` leaves the address, count and `tc` unchanged. `svc_req` shows, one cycle later, whether `dreq` was high while the channel was unmasked.
- R9: With `mode_auto` = 0, terminal count sets `masked`. The working address keeps its stepped value.
- R10: With `mode_auto` = 1, terminal count reloads the working page, address and count from the base copies, and `masked` stays 0.
- R11: A `mask_clr` pulse clears `masked` unless a masking terminal count happens in the same cycle. Transfers never change the base copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 page, 1 address, 2 count |
| wr_data | input | 16 | Write data |
| mode_dec | input | 1 | 1 = step the address down, 0 = up |
| mode_auto | input | 1 | 1 = reload from the base copies at terminal count |
| mask_clr | input | 1 | Clears the channel mask |
| dreq | input | 1 | Transfer request from the device |
| xfer_done | input | 1 | One transfer cycle has completed |
| bus_addr | output | 24 | Registered bus address |
| tc | output | 1 | Terminal-count pulse |
| masked | output | 1 | Channel mask state |
| svc_req | output | 1 | Registered request seen while unmasked |

## Verification
The hardest case to reach is the cycle where autoinitialize reloads the channel. From the ports, it is hard to tell a reload from a masked stop, or from an address that has just wrapped. The stimulus runs a channel with count 1 to terminal count. It checks that the address falls back to its start value while `masked` stays low. A further full run then has to produce a second `tc` after exactly two transfers, which shows that the count was restored as well. Wrap at both ends is reached by loading 0x0000 and 0xFFFF and stepping once. A second instance in word mode shares the stimulus, and loading two pages that differ only in bit 0 shows that the page LSB is dropped.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic [1:0] {
    SEL_PAGE  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/dma_ag_addr_regs.sv
module dma_ag_addr_regs #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_page,
  input  logic              ld_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  input  logic              dec,
  input  logic              reload,
  output logic [PAGE_W-1:0] cur_page,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [PAGE_W-1:0] base_page;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] addr_next;

  // step stays inside the address field; no carry reaches the page
  always_comb begin
    if (dec) addr_next = cur_addr - ADDR_W'(1);
    else     addr_next = cur_addr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_page <= '0;
      cur_page  <= '0;
    end else if (ld_page) begin
      base_page <= wr_data[PAGE_W-1:0];
      cur_page  <= wr_data[PAGE_W-1:0];
    end else if (reload) begin
      cur_page  <= base_page;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (ld_addr) begin
      base_addr <= wr_data[ADDR_W-1:0];
      cur_addr  <= wr_data[ADDR_W-1:0];
    end else if (reload) begin
      cur_addr  <= base_addr;
    end else if (step) begin
      cur_addr  <= addr_next;
    end
  end

  // R6: incrementing past all-ones lands on zero
  p_addr_wrap_up_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && !ld_addr && !dec && cur_addr == {ADDR_W{1'b1}})
      |=> cur_addr == '0);

  // R11: transfers never alter the base copy
  p_base_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (!ld_addr) |=> $stable(base_addr));
endmodule

// File: rtl/dma_ag_count.sv
module dma_ag_count #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  input  logic              reload,
  output logic              at_zero
);
  logic [CNT_W-1:0] base_cnt;
  logic [CNT_W-1:0] cur_cnt;

  assign at_zero = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
    end else if (ld) begin
      base_cnt <= wr_data[CNT_W-1:0];
      cur_cnt  <= wr_data[CNT_W-1:0];
    end else if (reload) begin
      cur_cnt  <= base_cnt;
    end else if (step) begin
      cur_cnt  <= cur_cnt - CNT_W'(1);
    end
  end

  // R7: a non-reloading step at zero leaves the count at all-ones
  p_cnt_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && !ld && at_zero) |=> cur_cnt == {CNT_W{1'b1}});
endmodule

// File: rtl/dma_ag_fmt.sv
module dma_ag_fmt #(
  parameter int PAGE_W    = 8,
  parameter int ADDR_W    = 16,
  parameter bit WORD_MODE = 1'b0,
  localparam int OUT_W    = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] cur_page,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [OUT_W-1:0]  bus_addr
);
  logic [OUT_W-1:0] addr_comb;

  generate
    if (WORD_MODE) begin : g_word
      // word layout: address shifted up one, page bit 0 discarded
      logic page_lsb_dropped;
      assign page_lsb_dropped = cur_page[0] & 1'b0;
      assign addr_comb = {cur_page[PAGE_W-1:1], cur_addr, page_lsb_dropped};
    end else begin : g_byte
      assign addr_comb = {cur_page, cur_addr};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bus_addr <= '0;
    else     bus_addr <= addr_comb;
  end

  // R4: the lowest output bit never rises in word layout
  p_word_even_r4: assert property (@(posedge clk) disable iff (rst)
    WORD_MODE |=> bus_addr[0] == 1'b0);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int PAGE_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 16,
  parameter bit WORD_MODE = 1'b0,
  localparam int OUT_W    = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_dec,
  input  logic              mode_auto,
  input  logic              mask_clr,
  input  logic              dreq,
  input  logic              xfer_done,
  output logic [OUT_W-1:0]  bus_addr,
  output logic              tc,
  output logic              masked,
  output logic              svc_req
);
  import dma_ag_pkg::*;

  logic              accept;
  logic              at_zero;
  logic              term;
  logic              reload;
  logic              ld_page, ld_addr, ld_cnt;
  logic [PAGE_W-1:0] cur_page;
  logic [ADDR_W-1:0] cur_addr;

  assign ld_page = wr_en && (wr_sel == SEL_PAGE);
  assign ld_addr = wr_en && (wr_sel == SEL_ADDR);
  assign ld_cnt  = wr_en && (wr_sel == SEL_COUNT);
  assign accept  = xfer_done && dreq && !masked && !wr_en;
  assign term    = accept && at_zero;
  assign reload  = term && mode_auto;

  dma_ag_addr_regs #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .ld_page(ld_page), .ld_addr(ld_addr),
    .wr_data(wr_data), .step(accept), .dec(mode_dec), .reload(reload),
    .cur_page(cur_page), .cur_addr(cur_addr)
  );

  dma_ag_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .ld(ld_cnt), .wr_data(wr_data),
    .step(accept), .reload(reload), .at_zero(at_zero)
  );

  dma_ag_fmt #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .WORD_MODE(WORD_MODE)) u_fmt (
    .clk(clk), .rst(rst), .cur_page(cur_page), .cur_addr(cur_addr),
    .bus_addr(bus_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      masked  <= 1'b1;
      tc      <= 1'b0;
      svc_req <= 1'b0;
    end else begin
      tc      <= term;
      svc_req <= dreq && !masked;
      if (term && !mode_auto) masked <= 1'b1;
      else if (mask_clr)      masked <= 1'b0;
    end
  end

  // R7: tc only follows an accepted transfer
  p_tc_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    tc |-> $past(xfer_done && dreq && !masked && !wr_en));

  // R9: terminal count without autoinitialize masks the channel
  p_tc_masks_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && at_zero && !mode_auto) |=> masked);

  // R10: autoinitialize keeps an open channel open
  p_auto_open_r10: assert property (@(posedge clk) disable iff (rst)
    (accept && at_zero && mode_auto) |=> !masked);

  // R8: a masked channel with no write holds its address
  p_masked_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (masked && !wr_en) |=> $stable(cur_addr));
endmodule

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic        mode_dec = 1'b0, mode_auto = 1'b0, mask_clr = 1'b0;
  logic        dreq = 1'b0, xfer_done = 1'b0;
  logic [23:0] bus_addr, bus_addr_w;
  logic        tc, masked, svc_req, tc_w, masked_w, svc_req_w;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_addr_gen #(.WORD_MODE(1'b0)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_dec(mode_dec), .mode_auto(mode_auto), .mask_clr(mask_clr),
    .dreq(dreq), .xfer_done(xfer_done), .bus_addr(bus_addr), .tc(tc),
    .masked(masked), .svc_req(svc_req));

  dma_addr_gen #(.WORD_MODE(1'b1)) dut_w (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_dec(mode_dec), .mode_auto(mode_auto), .mask_clr(mask_clr),
    .dreq(dreq), .xfer_done(xfer_done), .bus_addr(bus_addr_w), .tc(tc_w),
    .masked(masked_w), .svc_req(svc_req_w));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
    @(negedge clk);
  endtask

  task automatic clear_mask();
    @(negedge clk); mask_clr = 1'b1;
    @(negedge clk); mask_clr = 1'b0;
  endtask

  // one transfer strobe; returns tc seen after the strobe edge
  task automatic xfer(output logic tc_seen);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0; tc_seen = tc;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 bus_addr", 32'(bus_addr), 32'h0);
    check("R1 tc", 32'(tc), 32'h0);
    check("R1 masked", 32'(masked), 32'h1);
    check("R1 svc_req", 32'(svc_req), 32'h0);
  endtask

  task automatic t_byte_run();
    logic t;
    mode_dec = 1'b0; mode_auto = 1'b0; dreq = 1'b1;
    wr(2'd0, 16'h0012); wr(2'd1, 16'h3400); wr(2'd2, 16'd2);
    check("R2 load shows on bus", 32'(bus_addr), 32'h123400);
    check("R4 word layout", 32'(bus_addr_w), 32'h126800);
    clear_mask();
    @(negedge clk);
    check("R11 mask cleared", 32'(masked), 32'h0);
    check("R8 svc_req open", 32'(svc_req), 32'h1);
    xfer(t); check("R3 R5 step up", 32'(bus_addr), 32'h123401);
    check("R7 no early tc", 32'(t), 32'h0);
    xfer(t); check("R5 second step", 32'(bus_addr), 32'h123402);
    xfer(t); check("R7 tc on N+1", 32'(t), 32'h1);
    check("R9 addr kept", 32'(bus_addr), 32'h123403);
    check("R9 masked at tc", 32'(masked), 32'h1);
    xfer(t); check("R8 masked ignores", 32'(bus_addr), 32'h123403);
    check("R8 no tc when masked", 32'(t), 32'h0);
  endtask

  task automatic t_dec_wrap();
    logic t;
    mode_dec = 1'b1;
    wr(2'd1, 16'h0000); wr(2'd2, 16'd1);
    clear_mask();
    xfer(t); check("R6 wrap down, page kept", 32'(bus_addr), 32'h12FFFF);
    check("R7 no tc yet", 32'(t), 32'h0);
    xfer(t); check("R5 step down", 32'(bus_addr), 32'h12FFFE);
    check("R7 tc count 1", 32'(t), 32'h1);
  endtask

  task automatic t_inc_wrap();
    logic t;
    mode_dec = 1'b0;
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'd0);
    clear_mask();
    xfer(t); check("R6 wrap up, page kept", 32'(bus_addr), 32'h120000);
    check("R7 count 0 one transfer", 32'(t), 32'h1);
  endtask

  task automatic t_dreq_low();
    logic t;
    wr(2'd1, 16'h0500); wr(2'd2, 16'd5);
    clear_mask();
    dreq = 1'b0;
    xfer(t); check("R8 dreq low ignored", 32'(bus_addr), 32'h120500);
    check("R8 svc_req low", 32'(svc_req), 32'h0);
    dreq = 1'b1;
  endtask

  task automatic t_autoinit();
    logic t;
    mode_auto = 1'b1;
    wr(2'd1, 16'h1000); wr(2'd2, 16'd1);
    clear_mask();
    xfer(t); check("R10 first step", 32'(bus_addr), 32'h121001);
    xfer(t); check("R10 tc", 32'(t), 32'h1);
    check("R10 addr restored", 32'(bus_addr), 32'h121000);
    check("R10 stays unmasked", 32'(masked), 32'h0);
    xfer(t); check("R10 restart step", 32'(bus_addr), 32'h121001);
    check("R10 no tc after reload", 32'(t), 32'h0);
    xfer(t); check("R10 count restored", 32'(t), 32'h1);
    mode_auto = 1'b0;
  endtask

  task automatic t_word();
    logic t;
    wr(2'd0, 16'h0013); wr(2'd1, 16'h2000); wr(2'd2, 16'd3);
    check("R4 page lsb dropped", 32'(bus_addr_w), 32'h124000);
    check("R3 byte keeps page lsb", 32'(bus_addr), 32'h132000);
    clear_mask();
    xfer(t); check("R4 word step", 32'(bus_addr_w), 32'h124002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_run();
    t_dec_wrap();
    t_inc_wrap();
    t_dreq_low();
    t_autoinit();
    t_word();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule